// File: doc/BRIEF.md
# Read-After-Write Interlock for a Non-Forwarding Five-Stage Pipeline

This block keeps dependent instructions from reading stale register values in an in-order pipeline with five stages and no forwarding paths. The register file is read in decode and written only in writeback. A result therefore cannot be read until the producing instruction has left writeback. Each cycle the block compares both source register numbers of the instruction in decode against the destinations of the three instructions ahead of it, in execute, memory and writeback. When any of them is a pending write, the block freezes fetch and decode and sends an empty slot into execute.

The block keeps its own record of the destinations downstream. At each rising edge the decode instruction's destination and write flag enter the first tracked stage, and the older entries shift down by one. When the block stalls, an empty entry with its write flag cleared enters instead. The surrounding pipeline applies the three outputs to the PC register, to the fetch/decode register and to the execute-stage control bits.

Top module: `dep_interlock`

## Requirements
- R1: When source A is nonzero and equals the destination of a write-enabled instruction in execute, memory or writeback, the block stalls in that same cycle: `pc_en`=0, `ifid_en`=0, `bubble`=1.
- R2: Source B is checked against the same three stages, and a match stalls in the same way as in R1.
- R3: Register 0 never causes a stall. This holds whether register 0 appears as a source in decode or as the destination of an instruction further down.
- R4: An instruction whose write flag is 0, such as a store, never causes a later instruction to stall, even when register numbers match.
- R5: When neither source matches a pending write, `pc_en`=1, `ifid_en`=1 and `bubble`=0.
- R6: Reset is synchronous and active high. While it is high, the outputs show no stall. The edge it is sampled on empties all three tracked stages, so nothing decoded before or during reset can cause a stall once reset is released.
- R7: The number of stall cycles depends on how far the dependent instruction is behind its producer. It is 3 cycles at distance one, 2 at distance two, 1 at distance three and 0 at distance four or more. The stall ends without any counter as the producer leaves writeback.
- R8: When both sources match pending writes of different producers, the stall lasts until the last of those producers has left writeback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; tracked stages advance on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | REG_W | First source register number of the decode instruction |
| src_b | input | REG_W | Second source register number of the decode instruction |
| id_rd | input | REG_W | Destination register number of the decode instruction |
| id_we | input | 1 | Decode instruction writes its destination |
| pc_en | output | 1 | 1 lets the PC advance; 0 holds it |
| ifid_en | output | 1 | 1 lets the fetch/decode register load; 0 holds it |
| bubble | output | 1 | 1 puts an empty slot with cleared write controls into execute |

## Verification
The stall outputs are a combinational function of the decode inputs and the tracked stages. A result is therefore due in the same cycle its inputs are presented. The bench changes inputs on the falling edge and samples 1 ns later, well before the next rising edge. A decode instruction's destination joins the tracked stages at the rising edge where it leaves decode, so its effect starts one cycle later and lasts three cycles. The vector table accounts for this with one row per cycle, repeating a held instruction for each stall cycle it is expected to spend in decode. The program-driven test counts stall cycles per instruction to check the distance rule.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // default sizing: eight architectural registers, three stages behind decode
  localparam int unsigned ILK_REG_W = 3;
  localparam int unsigned ILK_DEPTH = 3;
  // number of source operands compared per decode instruction
  localparam int unsigned ILK_NSRC  = 2;
endpackage

// File: rtl/ilk_dest_track.sv
module ilk_dest_track #(
  parameter  int unsigned REG_W  = 3,
  parameter  int unsigned DEPTH  = 3,
  localparam int unsigned FLAT_W = REG_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  push_rd,
  input  logic              push_we,
  input  logic              hold,
  output logic [FLAT_W-1:0] rd_flat,
  output logic [DEPTH-1:0]  live
);
  // entry 0 mirrors execute, DEPTH-1 mirrors writeback
  logic [DEPTH-1:0][REG_W-1:0] rd_q;
  logic [DEPTH-1:0]            live_q;

  // a write to register 0 is discarded here, so compares need no zero test on it
  logic entry_live;
  assign entry_live = push_we && (push_rd != '0) && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      live_q <= '0;
    end else begin
      rd_q[0]   <= hold ? '0 : push_rd;
      live_q[0] <= entry_live;
      for (int s = 1; s < DEPTH; s++) begin
        rd_q[s]   <= rd_q[s-1];
        live_q[s] <= live_q[s-1];
      end
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_out
    assign rd_flat[s*REG_W +: REG_W] = rd_q[s];
  end
  assign live = live_q;
endmodule

// File: rtl/ilk_src_match.sv
module ilk_src_match #(
  parameter  int unsigned REG_W  = 3,
  parameter  int unsigned DEPTH  = 3,
  localparam int unsigned FLAT_W = REG_W * DEPTH
) (
  input  logic [REG_W-1:0]  src,
  input  logic [FLAT_W-1:0] rd_flat,
  input  logic [DEPTH-1:0]  live,
  output logic              hit
);
  logic [DEPTH-1:0] stage_hit;

  for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
    assign stage_hit[s] = live[s] && (rd_flat[s*REG_W +: REG_W] == src);
  end

  // register 0 reads a constant and never waits
  assign hit = (src != '0) && (|stage_hit);
endmodule

// File: rtl/dep_interlock.sv
module dep_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned REG_W = ILK_REG_W,
  parameter int unsigned DEPTH = ILK_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] id_rd,
  input  logic             id_we,
  output logic             pc_en,
  output logic             ifid_en,
  output logic             bubble
);
  localparam int unsigned FLAT_W = REG_W * DEPTH;
  localparam int unsigned NSRC   = ILK_NSRC;

  logic [FLAT_W-1:0]          dn_rd;
  logic [DEPTH-1:0]           dn_live;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            src_hit;
  logic                       stall;

  assign srcs = {src_b, src_a};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ilk_src_match #(.REG_W(REG_W), .DEPTH(DEPTH)) u_match (
      .src     (srcs[g]),
      .rd_flat (dn_rd),
      .live    (dn_live),
      .hit     (src_hit[g])
    );
  end

  assign stall = (|src_hit) && !rst;

  ilk_dest_track #(.REG_W(REG_W), .DEPTH(DEPTH)) u_track (
    .clk     (clk),
    .rst     (rst),
    .push_rd (id_rd),
    .push_we (id_we),
    .hold    (stall),
    .rd_flat (dn_rd),
    .live    (dn_live)
  );

  assign pc_en   = !stall;
  assign ifid_en = !stall;
  assign bubble  = stall;
endmodule

// File: rtl/dep_interlock_chk.sv
module dep_interlock_chk #(
  parameter int unsigned REG_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] src_a,
  input logic [REG_W-1:0] src_b,
  input logic [REG_W-1:0] id_rd,
  input logic             id_we,
  input logic             pc_en,
  input logic             ifid_en,
  input logic             bubble
);
  // R1: a live producer that just left decode must stall a source-A reader next cycle
  p_adjacent_a_r1: assert property (@(posedge clk) disable iff (rst)
    (id_we && (id_rd != '0) && !bubble) |=> ((src_a != $past(id_rd)) || bubble));

  // R2: same for source B
  p_adjacent_b_r2: assert property (@(posedge clk) disable iff (rst)
    (id_we && (id_rd != '0) && !bubble) |=> ((src_b != $past(id_rd)) || bubble));

  // R3: an instruction reading only register 0 never waits
  p_zero_src_r3: assert property (@(posedge clk) disable iff (rst)
    ((src_a == '0) && (src_b == '0)) |-> !bubble);

  // R6: no stall while reset is high
  p_reset_quiet_r6: assert property (@(posedge clk)
    rst |-> (!bubble && pc_en && ifid_en));

  // R1: a stall freezes both front registers
  p_freeze_r1: assert property (@(posedge clk) disable iff (rst)
    bubble |-> (!pc_en && !ifid_en));
endmodule

bind dep_interlock dep_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_a   (src_a),
  .src_b   (src_b),
  .id_rd   (id_rd),
  .id_we   (id_we),
  .pc_en   (pc_en),
  .ifid_en (ifid_en),
  .bubble  (bubble)
);

// File: tb/sim_dep_interlock.sv
module sim_dep_interlock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] src_a = '0;
  logic [2:0] src_b = '0;
  logic [2:0] id_rd = '0;
  logic       id_we = 1'b0;
  logic       pc_en, ifid_en, bubble;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dep_interlock u0 (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
    .id_rd(id_rd), .id_we(id_we),
    .pc_en(pc_en), .ifid_en(ifid_en), .bubble(bubble)
  );

  // one row per cycle: {src_a, src_b, id_rd, id_we, expect_stall}
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    {3'd1, 3'd2, 3'd3, 1'b1, 1'b0},  // R5 producer of r3
    {3'd3, 3'd4, 3'd5, 1'b1, 1'b1},  // R1 r3 in execute
    {3'd3, 3'd4, 3'd5, 1'b1, 1'b1},  // R1 r3 in memory
    {3'd3, 3'd4, 3'd5, 1'b1, 1'b1},  // R1 r3 in writeback
    {3'd3, 3'd4, 3'd5, 1'b1, 1'b0},  // R5 released
    {3'd0, 3'd0, 3'd6, 1'b1, 1'b0},  // R3 zero sources
    {3'd1, 3'd1, 3'd0, 1'b1, 1'b0},  // R3 writes r0
    {3'd5, 3'd2, 3'd2, 1'b0, 1'b1},  // R1 r5 three ahead, in writeback
    {3'd5, 3'd2, 3'd2, 1'b0, 1'b0},  // R7 one stall at distance three
    {3'd7, 3'd0, 3'd4, 1'b0, 1'b0},  // R5 store-like, no write
    {3'd4, 3'd0, 3'd7, 1'b1, 1'b0},  // R4 r4 from non-writing instr
    {3'd1, 3'd7, 3'd1, 1'b1, 1'b1},  // R2 r7 in execute via B
    {3'd1, 3'd7, 3'd1, 1'b1, 1'b1},  // R2
    {3'd1, 3'd7, 3'd1, 1'b1, 1'b1},  // R2
    {3'd1, 3'd7, 3'd1, 1'b1, 1'b0},  // R5 released
    {3'd2, 3'd2, 3'd2, 1'b1, 1'b0},  // R5
    {3'd1, 3'd2, 3'd3, 1'b1, 1'b1},  // R8 A->r1 memory, B->r2 execute
    {3'd1, 3'd2, 3'd3, 1'b1, 1'b1},  // R8
    {3'd1, 3'd2, 3'd3, 1'b1, 1'b1},  // R8 only B still pending
    {3'd1, 3'd2, 3'd3, 1'b1, 1'b0},  // R8 released after later producer
    {3'd3, 3'd0, 3'd0, 1'b0, 1'b1}   // R1 adjacent r3
  };
  localparam int VTAG [NV] = '{5, 1, 1, 1, 5, 3, 3, 1, 7, 5, 4, 2, 2, 2, 5, 5, 8, 8, 8, 8, 1};

  // program rows: {src_a, src_b, id_rd, id_we}
  localparam int NP = 7;
  localparam logic [9:0] PROG [NP] = '{
    {3'd0, 3'd0, 3'd6, 1'b1},
    {3'd0, 3'd0, 3'd1, 1'b1},
    {3'd6, 3'd0, 3'd2, 1'b1},  // distance two from r6 producer
    {3'd0, 3'd0, 3'd0, 1'b0},
    {3'd0, 3'd0, 3'd0, 1'b0},
    {3'd0, 3'd0, 3'd0, 1'b0},
    {3'd2, 3'd0, 3'd0, 1'b0}   // distance four from r2 producer
  };

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {bubble,pc_en,ifid_en} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: stall cycles actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] rd, input logic we);
    src_a = a; src_b = b; id_rd = rd; id_we = we;
  endtask

  localparam logic [2:0] NO_STALL = 3'b011;
  localparam logic [2:0] STALL    = 3'b100;

  initial begin
    int stalls [NP];
    int idx, cyc, total;
    // reset state, R6
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R6 reset state", {bubble, pc_en, ifid_en}, NO_STALL);
    drive(3'd0, 3'd0, 3'd3, 1'b1);          // live write decoded during reset
    @(negedge clk);
    drive(3'd3, 3'd0, 3'd3, 1'b1); #1;
    chk("R6 reset masks match", {bubble, pc_en, ifid_en}, NO_STALL);
    @(negedge clk);
    rst = 1'b0;
    drive(3'd3, 3'd0, 3'd0, 1'b0); #1;
    chk("R6 nothing captured in reset", {bubble, pc_en, ifid_en}, NO_STALL);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10:8], VEC[i][7:5], VEC[i][4:2], VEC[i][1]);
      #1;
      chk($sformatf("R%0d row %0d", VTAG[i], i), {bubble, pc_en, ifid_en},
          VEC[i][0] ? STALL : NO_STALL);
    end

    // R6: reset empties pending writes (r3 is live in execute now)
    @(negedge clk);
    drive(3'd0, 3'd0, 3'd0, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive(3'd3, 3'd0, 3'd0, 1'b0); #1;
    chk("R6 reset clears tracked stages", {bubble, pc_en, ifid_en}, NO_STALL);

    // R7: program with held decode driven by the outputs
    for (int i = 0; i < NP; i++) stalls[i] = 0;
    idx = 0; cyc = 0;
    while (idx < NP && cyc < 60) begin
      @(negedge clk);
      drive(PROG[idx][9:7], PROG[idx][6:4], PROG[idx][3:1], PROG[idx][0]);
      #1;
      if (bubble) stalls[idx]++;
      else idx++;
      cyc++;
    end
    @(negedge clk);
    drive(3'd0, 3'd0, 3'd0, 1'b0);
    total = 0;
    for (int i = 0; i < NP; i++) total += stalls[i];
    chk_int("R7 distance two", stalls[2], 2);
    chk_int("R7 distance four", stalls[6], 0);
    chk_int("R7 program total", total, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule